// File: doc/BRIEF.md
# Nested-Priority Interrupt Controller with Cascade Support

This block gathers eight interrupt request lines and presents one interrupt output to a processor. Each request is latched as pending, filtered by a mask, and ranked by fixed priority: input 0 ranks highest and input 7 lowest. A request is forwarded only when it ranks above every interrupt already being serviced. When the processor acknowledges, the winning request moves into the in-service set and the block returns a vector, which is a programmed base plus the input number. Software retires the highest-ranked in-service interrupt with a non-specific end-of-interrupt command.

Software talks to the block through a small address window. Address 0 is the command port and address 1 is the data port. Address 2 holds a per-input trigger select that software can read back. A command write with bit 4 set restarts configuration, and the data writes after it are then taken in a fixed order. The block can act as a cascade master, which names the input a downstream controller sits on, or as a downstream unit that answers only its own cascade ID.

The configuration state machine has five states:
- `ST_UNINIT`: the state after reset.
- `ST_WAIT_BASE`: waiting for the vector base.
- `ST_WAIT_CASC`: waiting for the cascade word.
- `ST_WAIT_MODE`: waiting for the optional mode word.
- `ST_READY`: normal operation.

Its transitions are:
- Any state goes to `ST_WAIT_BASE` on a restart command.
- `ST_WAIT_BASE` goes to `ST_WAIT_CASC` on a data write.
- `ST_WAIT_CASC` goes to `ST_WAIT_MODE` on a data write when a mode word was announced. Otherwise it goes to `ST_READY`.
- `ST_WAIT_MODE` goes to `ST_READY` on a data write.
- `ST_UNINIT` and `ST_READY` hold on every other event.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, the mask reads 0xFF at address 1, the trigger select reads 0x00 at address 2, `int_out` is low, and `vec_oe` is low. `int_out` stays low in every state other than `ST_READY`.
- R2: A write to address 0 with bit 4 set is a restart command. After it, the data writes (address 1) are taken in this order: the vector base, then the cascade word, then the mode word only if the restart command had bit 0 set. Every later data write loads the mask, and the mask reads back at address 1.
- R3: An acknowledge (`inta` high for one cycle) while `int_out` is high sets the in-service bit of the winning input. In the next cycle, `vec_oe` is high for one cycle and `vec_out` equals the base plus the input number.
- R4: Priority is fully nested, with input 0 highest. `int_out` is high only when some unmasked pending input ranks strictly above every in-service input.
- R5: A mask bit set to 1 keeps its input from raising `int_out`. The request still shows as pending.
- R6: A command write of 0x20 (bits 7..5 = 001, bits 4 and 3 clear) clears the highest-ranked in-service bit only.
- R7: A command write with bit 4 clear and bit 3 set selects what address 0 returns: low bits 11 select the in-service set and low bits 10 select the pending set. A restart command resets the selection to the pending set.
- R8: An edge-mode input becomes pending on a rising edge and stays pending until it is acknowledged. A line held high does not become pending again. A level-mode input is pending exactly while its line is high. Level mode applies when the input's trigger-select bit is set or when the restart command had bit 3 set.
- R9: The trigger select at address 2 is written and read back as eight bits, one per input, where 1 means level mode.
- R10: In master mode (`is_slave` low), when the winning input's bit is set in the cascade word, `cas_en` is high and `cas_out` carries the input number while the request is presented. The acknowledge then sets the in-service bit but drives no vector.
- R11: In downstream mode (`is_slave` high), an acknowledge is taken only when `cas_in` equals the low three bits of the cascade word. Otherwise it is ignored and leaves the pending set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 command, 1 data, 2 trigger select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq_in | input | 8 | Interrupt request lines |
| is_slave | input | 1 | Selects downstream cascade role |
| cas_in | input | 3 | Cascade ID presented by the master during acknowledge |
| inta | input | 1 | Interrupt acknowledge strobe |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector returned after acknowledge |
| vec_oe | output | 1 | Vector valid, one cycle |
| cas_out | output | 3 | Input number of the downstream controller being acknowledged |
| cas_en | output | 1 | The winning input carries a downstream controller |

## Verification
A stuck or skipped configuration state puts the data-port bytes into the wrong register. This shows at the next read of address 1, or at the next vector, which then carries a wrong base. A wrong in-service set shows on `int_out` in the cycle after an acknowledge or end-of-interrupt: lower-ranked requests are wrongly forwarded or wrongly blocked. The same fault also appears at the next in-service readback. A pending latch that misses an edge, or re-latches a held line, is exposed by the pending readback one cycle after the line changes.

// File: rtl/pic_pkg.sv
package pic_pkg;

    typedef enum logic [2:0] {
        ST_UNINIT,
        ST_WAIT_BASE,
        ST_WAIT_CASC,
        ST_WAIT_MODE,
        ST_READY
    } cfg_state_e;

    localparam logic [1:0] ADDR_CMD  = 2'd0;
    localparam logic [1:0] ADDR_DATA = 2'd1;
    localparam logic [1:0] ADDR_TRIG = 2'd2;

endpackage

// File: rtl/pic_cfg_fsm.sv
module pic_cfg_fsm
    import pic_pkg::*;
#(
    parameter int N_IN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      addr,
    input  logic [N_IN-1:0] wdata,
    output cfg_state_e      state,
    output logic [N_IN-1:0] base,
    output logic [N_IN-1:0] casc,
    output logic [N_IN-1:0] mask,
    output logic [N_IN-1:0] trig,
    output logic            all_level,
    output logic            read_isr,
    output logic            restart,
    output logic            eoi_stb
);
    cfg_state_e state_nx;
    logic       need_mode;
    logic       cmd_wr;
    logic       data_wr;

    assign cmd_wr  = wr_en && (addr == ADDR_CMD);
    assign data_wr = wr_en && (addr == ADDR_DATA);
    assign restart = cmd_wr && wdata[4];
    assign eoi_stb = cmd_wr && !wdata[4] && !wdata[3] && (wdata[7:5] == 3'b001)
                     && (state == ST_READY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_UNINIT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (restart) begin
            state_nx = ST_WAIT_BASE;
        end else begin
            unique case (state)
                ST_UNINIT:    state_nx = ST_UNINIT;
                ST_WAIT_BASE: if (data_wr) state_nx = ST_WAIT_CASC;
                ST_WAIT_CASC: if (data_wr) state_nx = need_mode ? ST_WAIT_MODE : ST_READY;
                ST_WAIT_MODE: if (data_wr) state_nx = ST_READY;
                ST_READY:     state_nx = ST_READY;
                default:      state_nx = ST_UNINIT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base      <= '0;
            casc      <= '0;
            mask      <= '1;
            trig      <= '0;
            all_level <= 1'b0;
            need_mode <= 1'b0;
            read_isr  <= 1'b0;
        end else begin
            if (restart) begin
                all_level <= wdata[3];
                need_mode <= wdata[0];
                read_isr  <= 1'b0;
            end else if (cmd_wr && wdata[3] && wdata[1]) begin
                read_isr  <= wdata[0];
            end
            if (data_wr) begin
                unique case (state)
                    ST_WAIT_BASE: base <= wdata;
                    ST_WAIT_CASC: casc <= wdata;
                    ST_READY:     mask <= wdata;
                    default:      ;
                endcase
            end
            if (wr_en && (addr == ADDR_TRIG)) trig <= wdata;
        end
    end
endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
    parameter int N_IN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] irq_in,
    input  logic [N_IN-1:0] level_sel,
    input  logic [N_IN-1:0] take,
    input  logic            flush,
    output logic [N_IN-1:0] pend
);
    for (genvar i = 0; i < N_IN; i++) begin : g_line
        logic prev_q;
        logic edge_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                edge_q <= 1'b0;
            end else begin
                prev_q <= irq_in[i];
                if (flush)                     edge_q <= 1'b0;
                else if (irq_in[i] && !prev_q) edge_q <= 1'b1;
                else if (take[i])              edge_q <= 1'b0;
            end
        end
        assign pend[i] = level_sel[i] ? irq_in[i] : edge_q;
    end
endmodule

// File: rtl/pic_prio.sv
module pic_prio #(
    parameter int N_IN = 8,
    localparam int IDW = $clog2(N_IN)
) (
    input  logic [N_IN-1:0] req,
    input  logic [N_IN-1:0] isr,
    output logic            grant,
    output logic [IDW-1:0]  win_idx,
    output logic [N_IN-1:0] isr_top
);
    logic           req_hit;
    logic           isr_hit;
    logic [IDW-1:0] isr_idx;

    always_comb begin
        req_hit = 1'b0;
        win_idx = '0;
        isr_hit = 1'b0;
        isr_idx = '0;
        for (int i = N_IN - 1; i >= 0; i--) begin
            if (req[i]) begin
                req_hit = 1'b1;
                win_idx = IDW'(i);
            end
            if (isr[i]) begin
                isr_hit = 1'b1;
                isr_idx = IDW'(i);
            end
        end
        grant   = req_hit && (!isr_hit || (win_idx < isr_idx));
        isr_top = isr_hit ? (N_IN'(1) << isr_idx) : '0;
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int N_IN = 8,
    localparam int IDW = $clog2(N_IN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      addr,
    input  logic [N_IN-1:0] wdata,
    output logic [N_IN-1:0] rdata,
    input  logic [N_IN-1:0] irq_in,
    input  logic            is_slave,
    input  logic [IDW-1:0]  cas_in,
    input  logic            inta,
    output logic            int_out,
    output logic [N_IN-1:0] vec_out,
    output logic            vec_oe,
    output logic [IDW-1:0]  cas_out,
    output logic            cas_en
);
    cfg_state_e      state;
    logic [N_IN-1:0] base, casc, mask, trig;
    logic            all_level, read_isr, restart, eoi_stb;
    logic [N_IN-1:0] irr_w, isr_q, isr_top, take_w;
    logic            grant, ready, ack_take, slave_here;
    logic [IDW-1:0]  win_idx;

    pic_cfg_fsm #(.N_IN(N_IN)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .state(state), .base(base), .casc(casc), .mask(mask), .trig(trig),
        .all_level(all_level), .read_isr(read_isr), .restart(restart),
        .eoi_stb(eoi_stb)
    );

    pic_req_latch #(.N_IN(N_IN)) u_req (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .level_sel(trig | {N_IN{all_level}}), .take(take_w), .flush(restart),
        .pend(irr_w)
    );

    pic_prio #(.N_IN(N_IN)) u_prio (
        .req(irr_w & ~mask), .isr(isr_q), .grant(grant),
        .win_idx(win_idx), .isr_top(isr_top)
    );

    assign ready      = (state == ST_READY);
    assign int_out    = ready && grant;
    assign slave_here = !is_slave && casc[win_idx];
    assign ack_take   = inta && int_out && (!is_slave || (cas_in == casc[IDW-1:0]));
    assign take_w     = ack_take ? (N_IN'(1) << win_idx) : '0;
    assign cas_out    = win_idx;
    assign cas_en     = int_out && slave_here;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            isr_q   <= '0;
            vec_out <= '0;
            vec_oe  <= 1'b0;
        end else begin
            if (restart) isr_q <= '0;
            else         isr_q <= (isr_q & ~(eoi_stb ? isr_top : '0)) | take_w;
            vec_oe  <= ack_take && !slave_here;
            if (ack_take) vec_out <= base + N_IN'(win_idx);
        end
    end

    always_comb begin
        unique case (addr)
            ADDR_CMD:  rdata = read_isr ? isr_q : irr_w;
            ADDR_DATA: rdata = mask;
            ADDR_TRIG: rdata = trig;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/pic_chk.sv
module pic_chk
    import pic_pkg::*;
#(
    parameter int N_IN = 8
) (
    input logic            clk,
    input logic            rst_n,
    input cfg_state_e      state,
    input logic            int_out,
    input logic            vec_oe,
    input logic            ack_take,
    input logic            eoi_stb,
    input logic            restart,
    input logic [N_IN-1:0] isr_q,
    input logic [N_IN-1:0] irr_w,
    input logic [N_IN-1:0] mask
);
    logic [N_IN-1:0] isr_low;
    assign isr_low = isr_q & (~isr_q + N_IN'(1));

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_READY) |-> !int_out); // R1

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((irr_w & ~mask) != '0)); // R5

    AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |-> $past(ack_take)); // R3

    AST_ACK_FILLS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_take && !restart) |=> (isr_q != '0)); // R3

    AST_NESTED_RANK: assert property (@(posedge clk) disable iff (!rst_n)
        (int_out && isr_q != '0) |-> ((irr_w & ~mask & (isr_low - N_IN'(1))) != '0)); // R4

    AST_EOI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_stb && isr_q != '0 && !ack_take) |=>
            ($countones(isr_q) == $countones($past(isr_q)) - 1)); // R6
endmodule

bind prio_irq_ctrl pic_chk #(.N_IN(N_IN)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .int_out(int_out), .vec_oe(vec_oe),
    .ack_take(ack_take), .eoi_stb(eoi_stb), .restart(restart), .isr_q(isr_q),
    .irr_w(irr_w), .mask(mask)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] irq_in = 8'h00;
    logic       is_slave = 1'b0;
    logic [2:0] cas_in = 3'd0;
    logic       inta = 1'b0;
    logic       int_out, vec_oe, cas_en;
    logic [7:0] vec_out;
    logic [2:0] cas_out;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0] vec;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_in(irq_in), .is_slave(is_slave), .cas_in(cas_in),
        .inta(inta), .int_out(int_out), .vec_out(vec_out), .vec_oe(vec_oe),
        .cas_out(cas_out), .cas_en(cas_en)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        chk(rdata, exp, tag);
    endtask

    task automatic tick_int(input logic exp, input string tag);
        @(negedge clk);
        #1;
        chk({7'd0, int_out}, {7'd0, exp}, tag);
    endtask

    task automatic ack(input logic [7:0] vec, input string tag);
        exp_t e;
        e.vec = vec; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk); inta = 1'b1;
        @(negedge clk); inta = 1'b0;
    endtask

    task automatic ack_silent(input string tag);
        @(negedge clk); inta = 1'b1;
        @(negedge clk); inta = 1'b0;
        #1;
        chk({7'd0, vec_oe}, 8'd0, tag);
    endtask

    // Monitor: pops expected vectors when the DUT presents one
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && vec_oe) begin
                if (exp_q.size() == 0) begin
                    chk(vec_out, 8'hxx, "R3 unexpected vector");
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(vec_out, e.vec, e.tag);
                end
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            if (exp_q.size() != 0) begin
                n_checks++; n_errors++;
                $display("FAIL R3: actual %0d vectors missing expected 0", exp_q.size());
            end
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(2'd1, 8'hFF, "R1 mask after reset");
        rd(2'd2, 8'h00, "R1 trigger select after reset");
        chk({7'd0, int_out}, 8'd0, "R1 int low");
        chk({7'd0, vec_oe}, 8'd0, "R1 vec_oe low");
        irq_in = 8'h01;
        tick_int(1'b0, "R1 no int before configuration");
        irq_in = 8'h00;

        // R2 configuration: edge, mode word present, cascade on input 2
        wr(2'd0, 8'h11); wr(2'd1, 8'h40); wr(2'd1, 8'h04); wr(2'd1, 8'h01);
        wr(2'd1, 8'h00);
        rd(2'd1, 8'h00, "R2 mask loaded after mode word");
        rd(2'd0, 8'h00, "R7 default read is pending set");

        // R3 / R8 single request
        irq_in = 8'h20;
        tick_int(1'b1, "R3 int on request 5");
        rd(2'd0, 8'h20, "R8 edge latched");
        ack(8'h45, "R3 vector 5");
        wr(2'd0, 8'h0B);
        rd(2'd0, 8'h20, "R7 in-service readback");
        tick_int(1'b0, "R4 int low after ack");
        wr(2'd0, 8'h0A);
        rd(2'd0, 8'h00, "R8 held line not relatched");

        // R4 / R6 nesting
        irq_in = 8'h68;
        tick_int(1'b1, "R4 higher request preempts");
        ack(8'h43, "R4 vector 3 wins over 6");
        wr(2'd0, 8'h0B);
        rd(2'd0, 8'h28, "R4 nested in-service");
        tick_int(1'b0, "R4 lower request blocked");
        wr(2'd0, 8'h20);
        rd(2'd0, 8'h20, "R6 EOI clears top bit only");
        tick_int(1'b0, "R4 input 6 still below 5");
        wr(2'd0, 8'h20);
        tick_int(1'b1, "R6 int after last EOI");
        ack(8'h46, "R3 vector 6");
        wr(2'd0, 8'h20);
        irq_in = 8'h00;

        // R5 mask
        wr(2'd0, 8'h0A);
        wr(2'd1, 8'h02);
        irq_in = 8'h02;
        tick_int(1'b0, "R5 masked input blocked");
        rd(2'd0, 8'h02, "R5 masked still pending");
        wr(2'd1, 8'h00);
        tick_int(1'b1, "R5 unmask raises int");
        ack(8'h41, "R3 vector 1");
        wr(2'd0, 8'h20);
        irq_in = 8'h00;

        // R10 master cascade on input 2
        irq_in = 8'h04;
        tick_int(1'b1, "R10 int for cascaded input");
        @(negedge clk); inta = 1'b1;
        #1;
        chk({7'd0, cas_en}, 8'd1, "R10 cas_en");
        chk({5'd0, cas_out}, 8'd2, "R10 cas_out");
        @(negedge clk); inta = 1'b0;
        #1;
        chk({7'd0, vec_oe}, 8'd0, "R10 no vector from master");
        wr(2'd0, 8'h0B);
        rd(2'd0, 8'h04, "R10 in-service set");
        wr(2'd0, 8'h20);
        rd(2'd0, 8'h00, "R6 EOI empties set");
        irq_in = 8'h00;
        wr(2'd0, 8'h0A);

        // R9 / R8 level vs edge
        wr(2'd2, 8'h80);
        rd(2'd2, 8'h80, "R9 trigger readback");
        irq_in = 8'h80;
        rd(2'd0, 8'h80, "R8 level pending");
        irq_in = 8'h00;
        rd(2'd0, 8'h00, "R8 level follows line");
        irq_in = 8'h10;
        rd(2'd0, 8'h10, "R8 edge pending");
        irq_in = 8'h00;
        rd(2'd0, 8'h10, "R8 edge holds after drop");
        ack(8'h44, "R3 vector 4");
        wr(2'd0, 8'h20);

        // R2 / R7 / R11 restart without mode word, downstream role
        wr(2'd0, 8'h0B);
        is_slave = 1'b1; cas_in = 3'd1;
        wr(2'd0, 8'h10); wr(2'd1, 8'h70); wr(2'd1, 8'h03); wr(2'd1, 8'h5A);
        rd(2'd1, 8'h5A, "R2 no mode word, mask loaded");
        irq_in = 8'h01;
        rd(2'd0, 8'h01, "R7 restart selects pending set");
        ack_silent("R11 wrong ID ignored");
        rd(2'd0, 8'h01, "R11 pending unchanged");
        cas_in = 3'd3;
        ack(8'h70, "R11 matching ID vector");
        wr(2'd0, 8'h0B);
        rd(2'd0, 8'h01, "R11 in-service set");
        wr(2'd0, 8'h20);
        irq_in = 8'h00;

        // R8 level from restart bit 3
        is_slave = 1'b0;
        wr(2'd0, 8'h18); wr(2'd1, 8'h20); wr(2'd1, 8'h00); wr(2'd1, 8'h00);
        irq_in = 8'h40;
        rd(2'd0, 8'h40, "R8 global level pending");
        irq_in = 8'h00;
        rd(2'd0, 8'h00, "R8 global level follows line");

        repeat (3) @(negedge clk);
        summary();
    end
endmodule